// File: doc/BRIEF.md
# Indirect DFE Register Access Controller

This block gives a host processor access to the decision-feedback equalizer settings of several receive channels through a narrow indirect window. The host does not address the equalizer fields directly. It selects a channel and a register offset, places a data word, and sets a trigger bit. The block then runs a transfer of fixed length into, or out of, a per-channel settings bank that it holds internally.

Each channel's bank holds a power enable, an adaptation enable, a 4-bit first post-tap coefficient, and two 3-bit post-tap coefficients that each carry a sign bit. The current contents of every bank are driven out continuously on a flat configuration bus, which feeds the equalizer hardware. The host reads busy and error flags to learn when a transfer has finished and whether it was rejected.

Top module: `dfe_indirect_ctrl`

## Requirements
- R1: After synchronous reset, every host register reads zero. Every channel's bank holds power=1, and all of its other fields are 0.
- R2: The host word addresses are: channel select 0x19 (8 bits, in [7:0]), control/status 0x1A, offset 0x1B (6 bits, in [5:0]), data 0x1C (16 bits). `host_rdata` is combinational while `host_rd` is high. Unimplemented bits, unmapped addresses and cycles with `host_rd` low all read 0.
- R3: A host write to control/status with bit 0 set starts a bank write. With bit 1 set it starts a bank read. If both bits are set, the write is performed. The trigger bits never read back as 1.
- R4: Control/status bit 8 (busy) is 1 for exactly LATENCY cycles, starting in the cycle after an accepted trigger. The transfer completes at the clock edge where busy falls.
- R5: A trigger with channel select ≥ NUM_CH, or with offset > 3, leaves busy low and sets control/status bit 9 (error) in the next cycle. It does not change the bank. The next accepted trigger clears the error.
- R6: A trigger that arrives while busy is 1 is ignored. A transfer uses the channel, offset and data that were present when it was accepted.
- R7: Offset 0: bit 1 is the power enable (0 powers the channel down), and bit 0 is the adaptation enable.
- R8: Offset 1: bits [3:0] are the first post-tap coefficient, 0 to 15.
- R9: Offsets 2 and 3: bits [2:0] are the coefficient (0 to 7) of the second and third post tap, and bit 3 is its sign (1 positive, 0 negative).
- R10: Bank bits outside the defined fields ignore writes and read as 0. A completed read loads the zero-extended field value into the data register.
- R11: Channel c occupies `eq_cfg[14c+13:14c]`, with fields in this order: [13] power, [12] adapt, [11:8] tap 1, [7] tap 2 sign, [6:4] tap 2, [3] tap 3 sign, [2:0] tap 3.
- R12: A transfer changes only the selected channel's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 7 | Host word address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| eq_cfg | output | NUM_CH*14 | Per-channel equalizer settings |

## Verification
Host register reads are combinational, so the bench compares each read at the falling edge inside the same cycle as the strobe. A trigger written at edge E shows busy in the reads of the next LATENCY cycles, and an idle status in the read after them. `eq_cfg` and the data register take the transfer's result at edge E+LATENCY, and the bench samples them only after that edge. A rejected trigger shows its error in the very next cycle's read.

// File: rtl/dfe_ctrl_pkg.sv
package dfe_ctrl_pkg;

    localparam int HOST_AW  = 7;
    localparam int HOST_DW  = 16;
    localparam int CHSEL_W  = 8;
    localparam int OFFS_W   = 6;
    localparam int CFG_W    = 14;
    localparam int LAST_OFFS = 3;

    localparam logic [HOST_AW-1:0] ADDR_CHSEL = 7'h19;
    localparam logic [HOST_AW-1:0] ADDR_CSR   = 7'h1A;
    localparam logic [HOST_AW-1:0] ADDR_OFFS  = 7'h1B;
    localparam logic [HOST_AW-1:0] ADDR_DATA  = 7'h1C;

    localparam int CSR_TRIG_WR = 0;
    localparam int CSR_TRIG_RD = 1;
    localparam int CSR_BUSY    = 8;
    localparam int CSR_ERR     = 9;

    // Packed order fixes the eq_cfg field layout, MSB first.
    typedef struct packed {
        logic       power;
        logic       adapt;
        logic [3:0] tap1;
        logic       t2_pos;
        logic [2:0] tap2;
        logic       t3_pos;
        logic [2:0] tap3;
    } eq_bank_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } xfer_op_t;

    typedef struct packed {
        xfer_op_t             op;
        logic [CHSEL_W-1:0]   ch;
        logic [OFFS_W-1:0]    offs;
        logic [HOST_DW-1:0]   wdata;
    } xfer_req_t;

    localparam eq_bank_t BANK_RESET = '{power: 1'b1, default: '0};

    function automatic logic [HOST_DW-1:0] bank_read(eq_bank_t b,
                                                      logic [OFFS_W-1:0] o);
        logic [HOST_DW-1:0] v;
        v = '0;
        case (o)
            6'd0: v[1:0] = {b.power, b.adapt};
            6'd1: v[3:0] = b.tap1;
            6'd2: v[3:0] = {b.t2_pos, b.tap2};
            6'd3: v[3:0] = {b.t3_pos, b.tap3};
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic eq_bank_t bank_write(eq_bank_t b,
                                            logic [OFFS_W-1:0] o,
                                            logic [3:0] d);
        eq_bank_t n;
        n = b;
        case (o)
            6'd0: begin
                n.power = d[1];
                n.adapt = d[0];
            end
            6'd1: n.tap1 = d;
            6'd2: begin
                n.t2_pos = d[3];
                n.tap2   = d[2:0];
            end
            6'd3: begin
                n.t3_pos = d[3];
                n.tap3   = d[2:0];
            end
            default: n = b;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dfe_host_regs.sv
module dfe_host_regs
    import dfe_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HOST_AW-1:0]   host_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [HOST_DW-1:0]   host_wdata,
    input  logic                 busy,
    input  logic                 err,
    input  logic                 rd_done,
    input  logic [HOST_DW-1:0]   rd_word,
    output logic [HOST_DW-1:0]   host_rdata,
    output logic [CHSEL_W-1:0]   chsel,
    output logic [OFFS_W-1:0]    offs,
    output logic [HOST_DW-1:0]   data_reg,
    output logic                 trig_wr,
    output logic                 trig_rd
);

    logic csr_hit;

    assign csr_hit = host_wr && (host_addr == ADDR_CSR);
    assign trig_wr = csr_hit && host_wdata[CSR_TRIG_WR];
    assign trig_rd = csr_hit && host_wdata[CSR_TRIG_RD];

    always_ff @(posedge clk) begin
        if (rst) begin
            chsel    <= '0;
            offs     <= '0;
            data_reg <= '0;
        end else begin
            if (host_wr && host_addr == ADDR_CHSEL)
                chsel <= host_wdata[CHSEL_W-1:0];
            if (host_wr && host_addr == ADDR_OFFS)
                offs <= host_wdata[OFFS_W-1:0];
            // A completing read takes precedence over a host data write.
            if (rd_done)
                data_reg <= rd_word;
            else if (host_wr && host_addr == ADDR_DATA)
                data_reg <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (host_addr)
                ADDR_CHSEL: host_rdata[CHSEL_W-1:0] = chsel;
                ADDR_CSR: begin
                    host_rdata[CSR_BUSY] = busy;
                    host_rdata[CSR_ERR]  = err;
                end
                ADDR_OFFS:  host_rdata[OFFS_W-1:0] = offs;
                ADDR_DATA:  host_rdata = data_reg;
                default:    host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dfe_xfer_seq.sv
module dfe_xfer_seq
    import dfe_ctrl_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int LATENCY = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_wr,
    input  logic                 trig_rd,
    input  logic [CHSEL_W-1:0]   chsel,
    input  logic [OFFS_W-1:0]    offs,
    input  logic [HOST_DW-1:0]   data_reg,
    output logic                 busy,
    output logic                 err,
    output xfer_req_t            req
);

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0]   CNT_LOAD = CNT_W'(LATENCY - 1);
    localparam logic [CHSEL_W-1:0] CH_LIMIT = CHSEL_W'(NUM_CH);
    localparam logic [OFFS_W-1:0]  OFFS_MAX = OFFS_W'(LAST_OFFS);

    logic [CNT_W-1:0] cnt;
    xfer_req_t        held;
    logic             any_trig;
    logic             target_ok;

    assign any_trig  = trig_wr || trig_rd;
    assign target_ok = (chsel < CH_LIMIT) && (offs <= OFFS_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            err  <= 1'b0;
            cnt  <= '0;
            held <= '0;
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end else if (any_trig) begin
            if (target_ok) begin
                busy       <= 1'b1;
                err        <= 1'b0;
                cnt        <= CNT_LOAD;
                held.op    <= trig_wr ? OP_WRITE : OP_READ;
                held.ch    <= chsel;
                held.offs  <= offs;
                held.wdata <= data_reg;
            end else begin
                err <= 1'b1;
            end
        end
    end

    // The request is presented in the last busy cycle and is taken at the
    // edge where busy falls.
    always_comb begin
        req = held;
        if (!(busy && cnt == '0))
            req.op = OP_NONE;
    end

endmodule

// File: rtl/dfe_tap_bank.sv
module dfe_tap_bank
    import dfe_ctrl_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  xfer_req_t                req,
    output logic [HOST_DW-1:0]       rd_word,
    output logic [NUM_CH*CFG_W-1:0]  eq_cfg
);

    eq_bank_t bank [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [CHSEL_W-1:0] MY_CH = CHSEL_W'(g);

        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= BANK_RESET;
            else if (req.op == OP_WRITE && req.ch == MY_CH)
                bank[g] <= bank_write(bank[g], req.offs, req.wdata[3:0]);
        end

        assign eq_cfg[g*CFG_W +: CFG_W] = bank[g];
    end

    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (req.ch == CHSEL_W'(c))
                rd_word = bank_read(bank[c], req.offs);
        end
    end

endmodule

// File: rtl/dfe_indirect_ctrl.sv
module dfe_indirect_ctrl
    import dfe_ctrl_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int LATENCY = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [6:0]               host_addr,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [15:0]              host_wdata,
    output logic [15:0]              host_rdata,
    output logic [NUM_CH*14-1:0]     eq_cfg
);

    logic [CHSEL_W-1:0] chsel;
    logic [OFFS_W-1:0]  offs;
    logic [HOST_DW-1:0] data_reg;
    logic [HOST_DW-1:0] rd_word;
    logic               trig_wr;
    logic               trig_rd;
    logic               busy_w;
    logic               err_w;
    xfer_req_t          req;

    dfe_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .busy       (busy_w),
        .err        (err_w),
        .rd_done    (req.op == OP_READ),
        .rd_word    (rd_word),
        .host_rdata (host_rdata),
        .chsel      (chsel),
        .offs       (offs),
        .data_reg   (data_reg),
        .trig_wr    (trig_wr),
        .trig_rd    (trig_rd)
    );

    dfe_xfer_seq #(
        .NUM_CH  (NUM_CH),
        .LATENCY (LATENCY)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .trig_wr  (trig_wr),
        .trig_rd  (trig_rd),
        .chsel    (chsel),
        .offs     (offs),
        .data_reg (data_reg),
        .busy     (busy_w),
        .err      (err_w),
        .req      (req)
    );

    dfe_tap_bank #(
        .NUM_CH (NUM_CH)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rd_word (rd_word),
        .eq_cfg  (eq_cfg)
    );

endmodule

// File: rtl/dfe_indirect_ctrl_chk.sv
module dfe_indirect_ctrl_chk #(
    parameter int NUM_CH  = 4,
    parameter int LATENCY = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [6:0]            host_addr,
    input logic                  host_rd,
    input logic [15:0]           host_rdata,
    input logic                  busy,
    input logic                  err,
    input logic [NUM_CH*14-1:0]  eq_cfg
);

    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (busy)
            run_cnt <= run_cnt + 16'd1;
        else
            run_cnt <= '0;
    end

    // R4: every busy window lasts exactly LATENCY cycles
    a_r4_busy_window: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == 16'(LATENCY)));

    // R5: error and busy are never reported together
    a_r5_err_excl_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !err);

    // R12: settings change only at transfer completion
    a_r12_bank_quiet: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(eq_cfg));

    // R3: trigger bits never read back set
    a_r3_trig_selfclear: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 7'h1A) |-> (host_rdata[1:0] == 2'b00));

    // R2: offset register reads only six bits
    a_r2_offs_width: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 7'h1B) |-> (host_rdata[15:6] == 10'd0));

    // R2: no data appears without a read strobe
    a_r2_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !host_rd |-> (host_rdata == 16'd0));

endmodule

bind dfe_indirect_ctrl dfe_indirect_ctrl_chk #(
    .NUM_CH  (NUM_CH),
    .LATENCY (LATENCY)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .busy       (busy_w),
    .err        (err_w),
    .eq_cfg     (eq_cfg)
);

// File: tb/tb_dfe_indirect_ctrl.sv
module tb_dfe_indirect_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int LATENCY    = 4;

    localparam logic [6:0] A_CH   = 7'h19;
    localparam logic [6:0] A_CSR  = 7'h1A;
    localparam logic [6:0] A_OFFS = 7'h1B;
    localparam logic [6:0] A_DATA = 7'h1C;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [6:0]              host_addr = '0;
    logic                    host_wr = 1'b0;
    logic                    host_rd = 1'b0;
    logic [15:0]             host_wdata = '0;
    logic [15:0]             host_rdata;
    logic [NUM_CH*14-1:0]    eq_cfg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dfe_indirect_ctrl #(.NUM_CH(NUM_CH), .LATENCY(LATENCY)) dut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eq_cfg     (eq_cfg)
    );

    // Monitor: compares each read strobe against the scoreboard head.
    always @(negedge clk) begin
        if (host_rd && exp_q.size() > 0) begin
            logic [15:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (host_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", t, host_rdata, e);
            end
        end
    end

    task automatic host_write(input logic [6:0] a, input logic [15:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(posedge clk); #1;
        host_wr    = 1'b0;
    endtask

    task automatic host_read(input logic [6:0] a, input logic [15:0] e,
                             input string t);
        host_addr = a;
        host_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        host_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_ch(input int c, input logic [13:0] e, input string t);
        n_chk++;
        if (eq_cfg[c*14 +: 14] !== e) begin
            n_fail++;
            $display("FAIL %s: ch%0d got %h expected %h", t, c,
                     eq_cfg[c*14 +: 14], e);
        end
    endtask

    task automatic xfer(input logic [7:0] ch, input logic [5:0] o,
                        input logic [15:0] d, input logic [15:0] trig);
        host_write(A_CH, {8'd0, ch});
        host_write(A_OFFS, {10'd0, o});
        host_write(A_DATA, d);
        host_write(A_CSR, trig);
        idle(LATENCY);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int c = 0; c < NUM_CH; c++) check_ch(c, 14'h2000, "R1 reset bank");
        host_read(A_CSR,  16'h0000, "R1 csr");
        host_read(A_DATA, 16'h0000, "R1 data");
        host_read(A_OFFS, 16'h0000, "R1 offs");
        host_read(A_CH,   16'h0000, "R1 chsel");

        // R2 register widths and map
        host_write(A_CH, 16'h01FF);
        host_read(A_CH, 16'h00FF, "R2 chsel width");
        host_write(A_OFFS, 16'hFFFF);
        host_read(A_OFFS, 16'h003F, "R2 offs width");
        host_write(A_DATA, 16'hA5A5);
        host_read(A_DATA, 16'hA5A5, "R2 data");
        host_read(7'h10, 16'h0000, "R2 unmapped");

        // R7 offset 0 write, R4 busy window, R3 self-clearing triggers
        host_write(A_CH, 16'd1);
        host_write(A_OFFS, 16'd0);
        host_write(A_DATA, 16'hFFFD);
        host_write(A_CSR, 16'h0001);
        for (int k = 0; k < LATENCY; k++) host_read(A_CSR, 16'h0100, "R4 busy");
        host_read(A_CSR, 16'h0000, "R4 busy end R3 trig clear");
        check_ch(1, 14'h1000, "R7 power/adapt");

        // R10 read back zero-extended
        host_write(A_DATA, 16'h1234);
        host_write(A_CSR, 16'h0002);
        idle(LATENCY);
        host_read(A_DATA, 16'h0001, "R10 read offs0");

        // R8 first post tap
        xfer(8'd2, 6'd1, 16'hFFFB, 16'h0001);
        check_ch(2, 14'h2B00, "R8 tap1");
        xfer(8'd2, 6'd1, 16'h0000, 16'h0002);
        host_read(A_DATA, 16'h000B, "R8 R10 tap1 read");

        // R9 second/third taps with sign
        xfer(8'd2, 6'd2, 16'h000D, 16'h0001);
        xfer(8'd2, 6'd3, 16'hFFF6, 16'h0001);
        check_ch(2, 14'h2BD6, "R9 taps 2/3");
        xfer(8'd2, 6'd2, 16'hFFFF, 16'h0002);
        host_read(A_DATA, 16'h000D, "R9 tap2 read");
        xfer(8'd2, 6'd3, 16'hFFFF, 16'h0002);
        host_read(A_DATA, 16'h0006, "R9 R10 tap3 read");

        // R5 invalid channel and offset
        host_write(A_CH, 16'd4);
        host_write(A_OFFS, 16'd1);
        host_write(A_DATA, 16'h000F);
        host_write(A_CSR, 16'h0001);
        host_read(A_CSR, 16'h0200, "R5 bad channel");
        idle(LATENCY);
        host_read(A_CSR, 16'h0200, "R5 error held");
        check_ch(0, 14'h2000, "R5 bank untouched");
        host_write(A_CH, 16'd0);
        host_write(A_OFFS, 16'd4);
        host_write(A_CSR, 16'h0001);
        idle(LATENCY);
        host_read(A_CSR, 16'h0200, "R5 bad offset");
        check_ch(0, 14'h2000, "R5 bank untouched offs");
        host_write(A_OFFS, 16'd1);
        host_write(A_CSR, 16'h0002);
        host_read(A_CSR, 16'h0100, "R5 error cleared");
        idle(LATENCY);

        // R6 trigger while busy ignored, values latched at acceptance
        host_write(A_CH, 16'd0);
        host_write(A_OFFS, 16'd1);
        host_write(A_DATA, 16'h0005);
        host_write(A_CSR, 16'h0001);
        host_write(A_DATA, 16'h0009);
        host_write(A_CSR, 16'h0001);
        idle(LATENCY + 2);
        host_read(A_CSR, 16'h0000, "R6 idle after");
        check_ch(0, 14'h2500, "R6 ignored trigger");
        host_read(A_DATA, 16'h0009, "R6 data write while busy");

        // R3 both triggers: write wins
        xfer(8'd3, 6'd1, 16'h0007, 16'h0003);
        check_ch(3, 14'h2700, "R3 both bits write");
        host_read(A_DATA, 16'h0007, "R3 no read done");

        // R12 / R11 channel isolation and layout
        check_ch(0, 14'h2500, "R12 ch0");
        check_ch(1, 14'h1000, "R12 ch1");
        check_ch(2, 14'h2BD6, "R12 R11 ch2");
        check_ch(3, 14'h2700, "R12 ch3");

        idle(2);
        finish_run();
    end

endmodule